// File: doc/BRIEF.md
# Pre/Post Trigger Capture Controller

This block records a continuous stream of samples into an on-chip circular buffer and halts recording a programmable number of samples after an external trigger event. The buffer then holds a window of history around the event: samples from before the trigger and samples from after it. Software, or a parent sequencer, issues a start command. Each sample is presented with a one-cycle valid strobe. The trigger line may be asynchronous to the block clock.

While armed, the write pointer advances on every accepted sample and wraps from the last buffer location back to location zero, overwriting the oldest contents. The first trigger edge seen after the start command marks the next written sample as the trigger sample. A down-counter loaded from the delay input then counts further samples. When it runs out, writing stops.

After the stop, the block reports three things. The trigger sample's address tells where the event is. The location that would have been written next tells where the oldest sample is. A flag tells whether the buffer wrapped at least once, so a partly filled buffer can be told apart from a full one. A registered read port gives access to the stored contents.

Top module: `preTrigCapture`

## Requirements
- R1: After reset, busy, done, wrEn and wrapped are 0 and wrAddr is 0; sampleValid has no effect until a start command.
- R2: A startCmd pulse while idle or done makes busy 1 and done 0 on the next cycle, with wrAddr 0 and wrapped 0.
- R3: While busy, every cycle with sampleValid high asserts wrEn in that same cycle and writes sampleData at wrAddr, and wrAddr then increments by one. Without sampleValid, wrAddr holds its value.
- R4: A write at the last location (DEPTH-1) is followed by wrAddr 0, and wrapped is 1 from the next cycle until the next start.
- R5: A rising edge on trigAsync is registered through a two-stage synchronizer and edge detector. The first sample written from the second clock edge after the rise onward becomes the trigger sample, and trigIndex reports its address.
- R6: After the trigger sample, exactly postDelay further samples are written and done is then 1 (busy 0). In the done state, sampleValid causes no write and wrAddr stays put.
- R7: With postDelay equal to 0, done is 1 on the cycle right after the trigger sample is written.
- R8: oldestIndex equals the next location to be written. After done, trigIndex equals (oldestIndex - 1 - postDelay) modulo DEPTH.
- R9: Only the first trigger edge after a start is taken. Edges while counting down, idle or done change neither trigIndex nor the number of samples captured.
- R10: startCmd while busy is ignored: wrAddr, wrapped and the capture continue unchanged.
- R11: rdData presents the word stored at rdAddr one clock after rdAddr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | One-cycle start pulse |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | DATA_W | Sample word |
| trigAsync | input | 1 | Asynchronous trigger line, rising edge active |
| postDelay | input | CNT_W | Number of samples to keep after the trigger sample |
| rdAddr | input | ADDR_W | Buffer read address |
| rdData | output | DATA_W | Buffer word, one cycle after rdAddr |
| wrAddr | output | ADDR_W | Current buffer write address |
| wrEn | output | 1 | Buffer write enable |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture finished |
| wrapped | output | 1 | Buffer has wrapped since the last start |
| trigIndex | output | ADDR_W | Address of the trigger sample |
| oldestIndex | output | ADDR_W | Address of the oldest sample, the next write location |

## Verification
Captures are run in several regimes. A short pre-trigger run that never wraps is compared with a long one that wraps, which separates correct modulo arithmetic on trigIndex and the wrapped flag from plain linear addressing. A zero delay is set against non-zero delays to show that the final write lands on the right cycle. Extra trigger pulses during the countdown and after done, and start pulses mid-capture, show whether the block ignores events it must not act on. Seeded random gaps between samples and random delay and pre-trigger lengths check that pointer motion depends only on sampleValid. A full buffer readback then compares every written location with the bench's model.

// File: rtl/capPkg.sv
package capPkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_POST  = 2'd2,
    CAP_DONE  = 2'd3
  } capState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clearAll;     // reset pointer, wrap flag and counter for a new run
    logic writeSample;  // store sampleData at the write pointer
    logic markTrig;     // current write is the trigger sample
    logic loadCnt;      // load the post-trigger counter
    logic decCnt;       // count one post-trigger sample
  } capStrobes_t;

endpackage

// File: rtl/capTrigSync.sv
module capTrigSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseEdge
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] chain;
  logic         lastLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain     <= '0;
      lastLevel <= 1'b0;
    end else begin
      chain     <= {chain[MSB-1:0], asyncIn};
      lastLevel <= chain[MSB];
    end
  end

  assign riseEdge = chain[MSB] & ~lastLevel;
endmodule

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCmd,
  input  logic        sampleValid,
  input  logic        trigEdge,
  input  logic        cntOne,
  input  logic        delayZero,
  output capStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  capState_t state, stateNext;
  logic      trigPending, trigPendingNext;
  logic      acceptTrig;

  assign acceptTrig = (state == CAP_ARMED) && sampleValid && (trigPending || trigEdge);

  always_comb begin
    stateNext       = state;
    trigPendingNext = trigPending;
    strobes         = '0;
    unique case (state)
      CAP_IDLE, CAP_DONE: begin
        if (startCmd) begin
          strobes.clearAll = 1'b1;
          trigPendingNext  = 1'b0;
          stateNext        = CAP_ARMED;
        end
      end
      CAP_ARMED: begin
        strobes.writeSample = sampleValid;
        if (acceptTrig) begin
          strobes.markTrig = 1'b1;
          trigPendingNext  = 1'b0;
          if (delayZero) begin
            stateNext = CAP_DONE;
          end else begin
            strobes.loadCnt = 1'b1;
            stateNext       = CAP_POST;
          end
        end else if (trigEdge) begin
          trigPendingNext = 1'b1;
        end
      end
      CAP_POST: begin
        strobes.writeSample = sampleValid;
        strobes.decCnt      = sampleValid;
        if (sampleValid && cntOne) stateNext = CAP_DONE;
      end
      default: stateNext = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= CAP_IDLE;
      trigPending <= 1'b0;
    end else begin
      state       <= stateNext;
      trigPending <= trigPendingNext;
    end
  end

  assign busy = (state == CAP_ARMED) || (state == CAP_POST);
  assign done = (state == CAP_DONE);
endmodule

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobes_t       strobes,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [CNT_W-1:0]  postDelay,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] trigIdx,
  output logic              wrapped,
  output logic              cntOne,
  output logic              delayZero
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (strobes.writeSample) mem[wrPtr] <= sampleData;
    rdData <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      trigIdx <= '0;
      wrapped <= 1'b0;
      remain  <= '0;
    end else begin
      if (strobes.clearAll) begin
        wrPtr   <= '0;
        wrapped <= 1'b0;
        remain  <= '0;
      end else begin
        if (strobes.writeSample) begin
          wrPtr <= wrPtr + 1'b1;
          if (wrPtr == LAST_ADDR) wrapped <= 1'b1;
        end
        if (strobes.markTrig) trigIdx <= wrPtr;
        if (strobes.loadCnt) remain <= postDelay;
        else if (strobes.decCnt) remain <= remain - 1'b1;
      end
    end
  end

  assign cntOne    = (remain == CNT_W'(1));
  assign delayZero = (postDelay == '0);
endmodule

// File: rtl/preTrigCapture.sv
module preTrigCapture
  import capPkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              trigAsync,
  input  logic [CNT_W-1:0]  postDelay,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrEn,
  output logic              busy,
  output logic              done,
  output logic              wrapped,
  output logic [ADDR_W-1:0] trigIndex,
  output logic [ADDR_W-1:0] oldestIndex
);
  capStrobes_t strobes;
  logic        trigEdge;
  logic        cntOne;
  logic        delayZero;
  logic [ADDR_W-1:0] wrPtr;

  capTrigSync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (trigAsync),
    .riseEdge (trigEdge)
  );

  capCtrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startCmd    (startCmd),
    .sampleValid (sampleValid),
    .trigEdge    (trigEdge),
    .cntOne      (cntOne),
    .delayZero   (delayZero),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done)
  );

  capDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sampleData (sampleData),
    .postDelay  (postDelay),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .wrPtr      (wrPtr),
    .trigIdx    (trigIndex),
    .wrapped    (wrapped),
    .cntOne     (cntOne),
    .delayZero  (delayZero)
  );

  assign wrAddr      = wrPtr;
  assign oldestIndex = wrPtr;
  assign wrEn        = strobes.writeSample;
endmodule

// File: rtl/preTrigCaptureChk.sv
module preTrigCaptureChk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              startCmd,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              busy,
  input logic              done,
  input logic              wrapped,
  input logic [ADDR_W-1:0] trigIndex
);
  assert_idle_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy) |=> (busy && !done && wrAddr == '0 && !wrapped));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !startCmd) |=> $stable(wrAddr));

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == '1) |=> wrapped);

  assert_no_write_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startCmd) |=> done);

  assert_trig_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startCmd) |=> $stable(trigIndex));
endmodule

bind preTrigCapture preTrigCaptureChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startCmd  (startCmd),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .busy      (busy),
  .done      (done),
  .wrapped   (wrapped),
  .trigIndex (trigIndex)
);

// File: tb/preTrigCapture_tb_top.sv
module preTrigCapture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startCmd = 1'b0;
  logic sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic trigAsync = 1'b0;
  logic [CNT_W-1:0] postDelay = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] wrAddr;
  logic wrEn, busy, done, wrapped;
  logic [ADDR_W-1:0] trigIndex, oldestIndex;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  int expPtr;
  bit expWrapped;
  int expTrig;
  logic [DATA_W-1:0] modelMem [DEPTH];
  bit modelValid [DEPTH];

  preTrigCapture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .sampleValid(sampleValid),
    .sampleData(sampleData), .trigAsync(trigAsync), .postDelay(postDelay),
    .rdAddr(rdAddr), .rdData(rdData), .wrAddr(wrAddr), .wrEn(wrEn),
    .busy(busy), .done(done), .wrapped(wrapped), .trigIndex(trigIndex),
    .oldestIndex(oldestIndex)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int wrapAddr(input int a);
    return ((a % DEPTH) + DEPTH) % DEPTH;
  endfunction

  function automatic int expectedTrigFromOldest(input int oldest, input int delay);
    return wrapAddr(oldest - 1 - delay);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG_CYCLES) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG_CYCLES);
        summary();
      end
    end
  end

  // one accepted sample, entered and left at a negedge
  task automatic doSample(input logic [DATA_W-1:0] d, input string req);
    sampleValid = 1'b1;
    sampleData  = d;
    #1;
    chk({req, " R3 wrEn"}, int'(wrEn), 1);
    chk({req, " R3 wrAddr"}, int'(wrAddr), expPtr);
    chk({req, " R8 oldestIndex"}, int'(oldestIndex), expPtr);
    @(posedge clk);
    modelMem[expPtr]   = d;
    modelValid[expPtr] = 1'b1;
    if (expPtr == DEPTH - 1) expWrapped = 1'b1;
    expPtr = wrapAddr(expPtr + 1);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic gap(input int maxGap);
    int g;
    g = (maxGap == 0) ? 0 : int'($urandom_range(maxGap, 0));
    for (int i = 0; i < g; i++) begin
      #1;
      chk("R3 no write without valid", int'(wrEn), 0);
      @(negedge clk);
    end
    chk("R3 ptr holds", int'(wrAddr), expPtr);
  endtask

  task automatic pulseTrig();
    trigAsync = 1'b1;
    repeat (5) @(negedge clk);
    trigAsync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic readBack();
    for (int i = 0; i < DEPTH; i++) begin
      rdAddr = ADDR_W'(i);
      @(posedge clk);
      @(negedge clk);
      if (modelValid[i]) chk("R11 readback", int'(rdData), int'(modelMem[i]));
    end
  endtask

  task automatic runCase(input int pre, input int delay, input bit extraTrig, input int maxGap);
    string doneReq;
    int frozenPtr;
    doneReq = (delay == 0) ? "R7" : "R6";
    postDelay = CNT_W'(delay);
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    expPtr = 0;
    expWrapped = 1'b0;
    #1;
    chk("R2 busy", int'(busy), 1);
    chk("R2 done", int'(done), 0);
    chk("R2 wrAddr", int'(wrAddr), 0);
    chk("R2 wrapped", int'(wrapped), 0);
    for (int i = 0; i < pre; i++) begin
      if (i == pre / 2) begin
        startCmd = 1'b1;
        @(negedge clk);
        startCmd = 1'b0;
        #1;
        chk("R10 start ignored ptr", int'(wrAddr), expPtr);
        chk("R10 start ignored wrapped", int'(wrapped), int'(expWrapped));
        chk("R10 still busy", int'(busy), 1);
      end
      doSample(DATA_W'($urandom), "pre");
      gap(maxGap);
    end
    chk("R4 wrapped before trigger", int'(wrapped), int'(expWrapped));
    pulseTrig();
    chk("R5 armed until trigger sample", int'(busy), 1);
    expTrig = expPtr;
    doSample(DATA_W'($urandom), "trig");
    for (int k = 0; k < delay; k++) begin
      #1;
      chk({doneReq, " busy during post"}, int'(busy), 1);
      if (extraTrig && k == delay / 2) pulseTrig();
      doSample(DATA_W'($urandom), "post");
      gap(maxGap);
    end
    #1;
    chk({doneReq, " done"}, int'(done), 1);
    chk({doneReq, " busy low"}, int'(busy), 0);
    chk("R5 trigIndex", int'(trigIndex), expTrig);
    chk("R8 oldestIndex", int'(oldestIndex), expPtr);
    chk("R8 trig vs oldest", int'(trigIndex), expectedTrigFromOldest(expPtr, delay));
    chk("R4 wrapped", int'(wrapped), int'(expWrapped));
    frozenPtr = expPtr;
    sampleValid = 1'b1;
    for (int j = 0; j < 3; j++) begin
      #1;
      chk("R6 no write after done", int'(wrEn), 0);
      @(negedge clk);
    end
    sampleValid = 1'b0;
    chk("R6 ptr frozen", int'(wrAddr), frozenPtr);
    pulseTrig();
    chk("R9 trig in done ignored", int'(trigIndex), expTrig);
    chk("R9 still done", int'(done), 1);
    readBack();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 wrEn", int'(wrEn), 0);
    chk("R1 wrapped", int'(wrapped), 0);
    chk("R1 wrAddr", int'(wrAddr), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sampleValid = 1'b1;
    #1;
    chk("R1 idle ignores valid", int'(wrEn), 0);
    @(negedge clk);
    sampleValid = 1'b0;
    chk("R1 idle ptr", int'(wrAddr), 0);
    pulseTrig();
    chk("R9 trig in idle ignored", int'(busy), 0);

    runCase(10, 5, 1'b0, 0);
    runCase(50, 20, 1'b0, 2);
    runCase(7, 0, 1'b0, 1);
    runCase(40, 12, 1'b1, 1);
    runCase(31, 1, 1'b0, 0);
    for (int r = 0; r < 6; r++) begin
      runCase(int'($urandom_range(70, 2)), int'($urandom_range(40, 0)), r[0], 2);
    end
    summary();
  end
endmodule